// File: doc/BRIEF.md
# Cache Write-Policy Controller

This block is the sequencing engine of a set-associative cache whose lines hold four words. It sits between a processor load/store port and a word-wide main-memory port. It drives the index and tag of the pending access into an external tag lookup. It then reads back that lookup's verdict: hit or miss, the matching way, and the way chosen for replacement together with that way's stored tag. From that verdict it decides what reaches memory, writes words and tags into the cache arrays, and returns load data to the processor.

Each access carries its own policy bit. In store-through operation every store is also sent to memory. In deferred-store operation stores stay in the cache and mark the line modified. The controller keeps one modified flag per line. When a modified line is replaced, its words are copied out to memory before the new line is fetched. Stores that miss allocate a line under both policies. The replacement decision and the tag comparison live outside this block.

Top module: `cache_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, the processor port reports ready, no completion is signalled and no memory request is raised; every modified flag is cleared by reset.
- R2: Each accepted access first spends one lookup cycle on the indexed set. A load that hits returns the word held at its address with no memory traffic, and the completion pulse comes in the second cycle after acceptance.
- R3: A load miss fetches the whole line with four memory reads, at word offsets 0, 1, 2, 3 in that order, at address {request tag, index, offset}. It installs the tag on the last beat, returns the requested word and leaves the line unmodified.
- R4: A store-through store that hits writes the word into the cached line and makes exactly one memory write of that word at its own address.
- R5: A store-through store that misses fetches the line as in R3, merges the store word during the fill, then makes one memory write of the word; the line is not marked modified.
- R6: A deferred store that hits updates only the cached word and marks the line modified, with no memory traffic; completion comes in the second cycle after acceptance.
- R7: A deferred store that misses fetches the line as in R3, merges the store word and marks the line modified, with no memory write.
- R8: When any miss selects a replacement way whose modified flag is set, four memory writes of that line's words come first, at offsets 0 to 3 in order and at address {stored victim tag, index, offset}; the refill follows.
- R9: The port is ready only when the controller is idle. Once an access is accepted, ready stays low until a one-cycle completion pulse, and ready returns in the cycle after that pulse.
- R10: A raised memory request keeps its address, direction and write data unchanged until the cycle in which it is acknowledged.
- R11: The policy input is sampled only when an access is accepted; changing it while the access is in flight has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_mode_i | input | 1 | Policy of the access being accepted: 1 deferred store, 0 store-through |
| cpu_req_i | input | 1 | Access request, taken when cpu_ready_o is high |
| cpu_we_i | input | 1 | 1 store, 0 load |
| cpu_addr_i | input | AW | Word address: {tag, index, offset} |
| cpu_wdata_i | input | DW | Store data |
| cpu_ready_o | output | 1 | Controller idle and able to accept |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DW | Load data, valid with cpu_done_o |
| lk_hit_i | input | 1 | Lookup result: indexed set holds the tag |
| lk_hit_way_i | input | WAY_W | Way that matched |
| lk_vict_way_i | input | WAY_W | Way chosen for replacement |
| lk_vict_tag_i | input | TAG_W | Tag stored in the replacement way |
| arr_idx_o | output | IDX_W | Set index to the tag and data arrays |
| arr_way_o | output | WAY_W | Way addressed in the arrays |
| arr_off_o | output | OFF_W | Word offset addressed in the data array |
| arr_we_o | output | 1 | Data array word write |
| arr_wdata_o | output | DW | Data array write word |
| arr_rdata_i | input | DW | Data array read word at the driven address |
| tag_we_o | output | 1 | Install tag_o as a valid tag in arr_way_o |
| tag_o | output | TAG_W | Tag of the pending access |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transfer completes this cycle |

## Verification
Two actions share a single clock cycle. On the fill beat whose offset equals the store's offset, the refill and the store merge land together, and the word written into the array must be the store data, not the fetched word. Separately, under the deferred policy, the last fill beat that installs the tag also sets the modified flag. The bench provokes both with stores that miss at every offset, and judges them later: reads return the stored value, and a subsequent eviction carries that value to memory. Mixed-policy random traffic over four sets and eight tags forces modified lines to be replaced by both load and store misses. Each access's memory transactions are compared in order against a bench-computed list.

// File: rtl/cache_ctrl_pkg.sv
package cache_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_STORE,
    ST_DONE
  } cc_state_e;

endpackage

// File: rtl/cc_beat_cnt.sv
module cc_beat_cnt #(
  parameter int OFF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [OFF_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '1);

endmodule

// File: rtl/cc_dirty_store.sv
module cc_dirty_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAY_W-1:0] qry_way_i,
  output logic             qry_dirty_o,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic             set_i,
  input  logic             clr_i
);

  logic [SETS-1:0][WAYS-1:0] rows;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if ((set_i || clr_i) && idx_i == IDX_W'(s)) begin
        row_q[upd_way_i] <= set_i;
      end
    end
    assign rows[s] = row_q;
  end

  assign qry_dirty_o = rows[idx_i][qry_way_i];

endmodule

// File: rtl/cc_line_addr.sv
module cc_line_addr #(
  parameter int TAG_W = 5,
  parameter int IDX_W = 3,
  parameter int OFF_W = 2,
  parameter int AW    = TAG_W + IDX_W + OFF_W
) (
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [TAG_W-1:0] vic_tag_i,
  input  logic             use_vic_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [AW-1:0]    addr_o
);

  assign addr_o = {(use_vic_i ? vic_tag_i : req_tag_i), idx_i, off_i};

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_ctrl_pkg::*;
#(
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4,
  // derived
  parameter int OFF_W      = $clog2(LINE_WORDS),
  parameter int IDX_W      = $clog2(SETS),
  parameter int WAY_W      = $clog2(WAYS),
  parameter int TAG_W      = AW - IDX_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wb_mode_i,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic [DW-1:0]    cpu_wdata_i,
  output logic             cpu_ready_o,
  output logic             cpu_done_o,
  output logic [DW-1:0]    cpu_rdata_o,
  input  logic             lk_hit_i,
  input  logic [WAY_W-1:0] lk_hit_way_i,
  input  logic [WAY_W-1:0] lk_vict_way_i,
  input  logic [TAG_W-1:0] lk_vict_tag_i,
  output logic [IDX_W-1:0] arr_idx_o,
  output logic [WAY_W-1:0] arr_way_o,
  output logic [OFF_W-1:0] arr_off_o,
  output logic             arr_we_o,
  output logic [DW-1:0]    arr_wdata_o,
  input  logic [DW-1:0]    arr_rdata_i,
  output logic             tag_we_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i
);

  cc_state_e state_q, state_d;

  logic [TAG_W-1:0] tag_q, vtag_q;
  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] off_q;
  logic [WAY_W-1:0] way_q;
  logic             we_q, wb_q;
  logic [DW-1:0]    wdata_q, rdata_q;

  logic [OFF_W-1:0] beat;
  logic             beat_last;
  logic             vic_dirty;

  logic st_idle, st_look, st_evict, st_fill, st_store, st_done;
  logic accept, look_hit, look_miss, beat_done, fill_end, evict_end;
  logic merge_beat, store_defer, dirty_set, dirty_clr;
  logic [OFF_W-1:0] mem_off;

  assign st_idle  = (state_q == ST_IDLE);
  assign st_look  = (state_q == ST_LOOKUP);
  assign st_evict = (state_q == ST_EVICT);
  assign st_fill  = (state_q == ST_FILL);
  assign st_store = (state_q == ST_STORE);
  assign st_done  = (state_q == ST_DONE);

  assign accept      = st_idle && cpu_req_i;
  assign look_hit    = st_look && lk_hit_i;
  assign look_miss   = st_look && !lk_hit_i;
  assign beat_done   = (st_evict || st_fill) && mem_ack_i;
  assign fill_end    = st_fill && mem_ack_i && beat_last;
  assign evict_end   = st_evict && mem_ack_i && beat_last;
  assign merge_beat  = st_fill && we_q && (beat == off_q);
  assign store_defer = we_q && wb_q;
  assign dirty_set   = (look_hit && store_defer) || (fill_end && store_defer);
  assign dirty_clr   = fill_end && !store_defer;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_req_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (lk_hit_i)       state_d = (we_q && !wb_q) ? ST_STORE : ST_DONE;
        else if (vic_dirty) state_d = ST_EVICT;
        else                state_d = ST_FILL;
      end
      ST_EVICT:  if (evict_end) state_d = ST_FILL;
      ST_FILL:   if (fill_end)  state_d = (we_q && !wb_q) ? ST_STORE : ST_DONE;
      ST_STORE:  if (mem_ack_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      idx_q   <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      wb_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      {tag_q, idx_q, off_q} <= cpu_addr_i;
      we_q    <= cpu_we_i;
      wb_q    <= wb_mode_i;
      wdata_q <= cpu_wdata_i;
    end
  end

  // way / victim capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      way_q  <= '0;
      vtag_q <= '0;
    end else if (look_miss) begin
      way_q  <= lk_vict_way_i;
      vtag_q <= lk_vict_tag_i;
    end else if (look_hit) begin
      way_q  <= lk_hit_way_i;
    end
  end

  // load data return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (look_hit && !we_q) begin
      rdata_q <= arr_rdata_i;
    end else if (st_fill && mem_ack_i && !we_q && beat == off_q) begin
      rdata_q <= mem_rdata_i;
    end
  end

  cc_beat_cnt #(
    .OFF_W (OFF_W)
  ) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_look),
    .inc_i  (beat_done),
    .cnt_o  (beat),
    .last_o (beat_last)
  );

  cc_dirty_store #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W)
  ) u_dirty (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx_q),
    .qry_way_i   (lk_vict_way_i),
    .qry_dirty_o (vic_dirty),
    .upd_way_i   (arr_way_o),
    .set_i       (dirty_set),
    .clr_i       (dirty_clr)
  );

  assign mem_off = st_store ? off_q : beat;

  cc_line_addr #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .AW    (AW)
  ) u_maddr (
    .req_tag_i (tag_q),
    .vic_tag_i (vtag_q),
    .use_vic_i (st_evict),
    .idx_i     (idx_q),
    .off_i     (mem_off),
    .addr_o    (mem_addr_o)
  );

  // processor side
  assign cpu_ready_o = st_idle;
  assign cpu_done_o  = st_done;
  assign cpu_rdata_o = rdata_q;

  // array side
  assign arr_idx_o   = idx_q;
  assign tag_o       = tag_q;
  assign arr_way_o   = st_look ? lk_hit_way_i : way_q;
  assign arr_off_o   = (st_evict || st_fill) ? beat : off_q;
  assign arr_we_o    = (look_hit && we_q) || (st_fill && mem_ack_i);
  assign arr_wdata_o = (st_fill && !merge_beat) ? mem_rdata_i : wdata_q;
  assign tag_we_o    = fill_end;

  // memory side
  assign mem_req_o   = st_evict || st_fill || st_store;
  assign mem_we_o    = st_evict || st_store;
  assign mem_wdata_o = st_evict ? arr_rdata_i : wdata_q;

endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int OFF_W = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_req_i,
  input logic          cpu_ready_o,
  input logic          cpu_done_o,
  input logic          arr_we_o,
  input logic          tag_we_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);

  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

  logic [OFF_W-1:0] beat_nxt;
  assign beat_nxt = mem_addr_o[OFF_W-1:0] + ONE;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o |=> !cpu_ready_o);  // R9

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> cpu_ready_o && !cpu_done_o);  // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_req_o && !arr_we_o && !cpu_done_o);  // R9

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));  // R10

  AST_FILL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_we_o && (mem_addr_o[OFF_W-1:0] != '1)
    |=> mem_req_o && !mem_we_o && (mem_addr_o[OFF_W-1:0] == $past(beat_nxt)));  // R3

  AST_TAG_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> arr_we_o && mem_ack_i && mem_req_o && !mem_we_o);  // R3

endmodule

bind cache_ctrl cache_ctrl_chk #(
  .AW    (AW),
  .DW    (DW),
  .OFF_W (OFF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_ready_o (cpu_ready_o),
  .cpu_done_o  (cpu_done_o),
  .arr_we_o    (arr_we_o),
  .tag_we_o    (tag_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/cache_ctrl_bench.sv
`timescale 1ns/1ps
module cache_ctrl_bench;

  localparam int AW = 10, DW = 32, SETS = 8, WAYS = 4, LW = 4;
  localparam int OFF_W = 2, IDX_W = 3, WAY_W = 2, TAG_W = AW - IDX_W - OFF_W;
  localparam int MEM_N = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wb_mode = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0]    cpu_addr = '0;
  logic [DW-1:0]    cpu_wdata = '0;
  logic             cpu_ready, cpu_done;
  logic [DW-1:0]    cpu_rdata;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_hit_way, lk_vict_way;
  logic [TAG_W-1:0] lk_vict_tag;
  logic [IDX_W-1:0] arr_idx;
  logic [WAY_W-1:0] arr_way;
  logic [OFF_W-1:0] arr_off;
  logic             arr_we, tag_we;
  logic [DW-1:0]    arr_wdata, arr_rdata;
  logic [TAG_W-1:0] tag_o;
  logic             mem_req, mem_we;
  logic             mem_ack = 1'b0;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  logic [DW-1:0]    mem_rdata = '0;

  always #10 clk = ~clk;

  cache_ctrl u_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wb_mode_i(wb_mode),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .lk_hit_i(lk_hit), .lk_hit_way_i(lk_hit_way), .lk_vict_way_i(lk_vict_way),
    .lk_vict_tag_i(lk_vict_tag),
    .arr_idx_o(arr_idx), .arr_way_o(arr_way), .arr_off_o(arr_off), .arr_we_o(arr_we),
    .arr_wdata_o(arr_wdata), .arr_rdata_i(arr_rdata), .tag_we_o(tag_we), .tag_o(tag_o),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- cache array environment ----------------
  logic [TAG_W-1:0] env_tag [SETS][WAYS];
  logic             env_val [SETS][WAYS];
  logic [DW-1:0]    env_dat [SETS][WAYS][LW];
  logic [WAY_W-1:0] vsel = '0;

  always_comb begin
    lk_hit = 1'b0;
    lk_hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_hit && env_val[arr_idx][w] && env_tag[arr_idx][w] == tag_o) begin
        lk_hit = 1'b1;
        lk_hit_way = WAY_W'(w);
      end
    end
    lk_vict_way = vsel;
    lk_vict_tag = env_tag[arr_idx][vsel];
    arr_rdata   = env_dat[arr_idx][arr_way][arr_off];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          env_val[s][w] <= 1'b0;
          env_tag[s][w] <= '0;
        end
    end else begin
      if (arr_we) env_dat[arr_idx][arr_way][arr_off] <= arr_wdata;
      if (tag_we) begin
        env_tag[arr_idx][arr_way] <= tag_o;
        env_val[arr_idx][arr_way] <= 1'b1;
      end
    end
  end

  // ---------------- main memory environment ----------------
  logic [DW-1:0] mem  [MEM_N];
  logic [DW-1:0] gold [MEM_N];
  int            log_n = 0;
  logic          log_we   [16];
  logic [AW-1:0] log_addr [16];
  logic [DW-1:0] log_dat  [16];
  bit            seen = 0;
  logic [AW-1:0] snap_addr;
  logic          snap_we;
  logic [DW-1:0] snap_wd;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req && rst_n) begin
      if (!seen) begin
        seen = 1;
        snap_addr = mem_addr;
        snap_we   = mem_we;
        snap_wd   = mem_wdata;
      end else begin
        seen = 0;
        check(snap_addr == mem_addr && snap_we == mem_we && (!mem_we || snap_wd == mem_wdata),
              "R10", "request held until ack", {mem_we, mem_addr}, {snap_we, snap_addr});
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else        mem_rdata <= mem[mem_addr];
        if (log_n < 16) begin
          log_we[log_n]   = mem_we;
          log_addr[log_n] = mem_addr;
          log_dat[log_n]  = mem_wdata;
        end
        log_n++;
      end
    end else begin
      seen = 0;
    end
  end

  // ---------------- reference model ----------------
  bit               r_val   [SETS][WAYS];
  bit               r_dirty [SETS][WAYS];
  logic [TAG_W-1:0] r_tag   [SETS][WAYS];
  int               e_n;
  logic             e_we   [16];
  logic [AW-1:0]    e_addr [16];
  logic [DW-1:0]    e_dat  [16];
  logic [31:0]      seed = 32'h1234_5678;

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [DW-1:0] init_word(int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic push(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    e_we[e_n] = we; e_addr[e_n] = a; e_dat[e_n] = d; e_n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req = 1'b0;
    repeat (2) @(negedge clk);
    check(cpu_ready && !cpu_done && !mem_req, "R1", "port state in reset",
          {cpu_ready, cpu_done, mem_req}, 3'b100);
    for (int a = 0; a < MEM_N; a++) begin
      mem[a]  = init_word(a);
      gold[a] = init_word(a);
    end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        r_val[s][w] = 0; r_dirty[s][w] = 0; r_tag[s][w] = '0;
      end
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready && !cpu_done && !mem_req, "R1", "port state after reset",
          {cpu_ready, cpu_done, mem_req}, 3'b100);
  endtask

  task automatic access(bit we, bit wb, logic [AW-1:0] addr, logic [DW-1:0] wd,
                        logic [WAY_W-1:0] vic);
    logic [TAG_W-1:0] t;
    logic [IDX_W-1:0] ix;
    bit               hit, evict, ok, busy_ok;
    int               hw, lat;
    string            cls;
    logic [DW-1:0]    exp_rd, got;
    t  = addr[AW-1:OFF_W+IDX_W];
    ix = addr[OFF_W+IDX_W-1:OFF_W];
    hit = 0; hw = 0;
    for (int w = 0; w < WAYS; w++)
      if (!hit && r_val[ix][w] && r_tag[ix][w] == t) begin hit = 1; hw = w; end
    evict = !hit && r_val[ix][vic] && r_dirty[ix][vic];
    e_n = 0;
    if (evict)
      for (int o = 0; o < LW; o++)
        push(1'b1, {r_tag[ix][vic], ix, OFF_W'(o)}, gold[{r_tag[ix][vic], ix, OFF_W'(o)}]);
    if (!hit)
      for (int o = 0; o < LW; o++) push(1'b0, {t, ix, OFF_W'(o)}, '0);
    if (we && !wb) push(1'b1, addr, wd);
    exp_rd = gold[addr];
    if (evict)           cls = "R8 R11";
    else if (!we)        cls = hit ? "R2 R11" : "R3 R11";
    else if (!wb)        cls = hit ? "R4 R11" : "R5 R11";
    else                 cls = hit ? "R6 R11" : "R7 R11";

    @(negedge clk);
    vsel = vic; log_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; wb_mode = wb;
    @(negedge clk);
    cpu_req = 1'b0; wb_mode = !wb;  // flip policy while in flight
    lat = 1; busy_ok = 1;
    while (!cpu_done && lat < 300) begin
      if (cpu_ready) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    got = cpu_rdata;
    @(negedge clk);
    busy_ok = busy_ok && cpu_ready && !cpu_done && lat < 300;
    check(busy_ok, "R9", "busy until single done pulse", lat, 0);

    ok = (log_n == e_n);
    for (int k = 0; k < e_n && k < 16; k++)
      ok = ok && log_we[k] == e_we[k] && log_addr[k] == e_addr[k] &&
           (!e_we[k] || log_dat[k] == e_dat[k]);
    check(ok, cls, "memory transaction list (count shown)", log_n, e_n);
    if (!we) check(got == exp_rd, cls, "load data", got, exp_rd);
    if (hit && (!we || wb)) check(lat == 2, cls, "hit completion latency", lat, 2);

    if (!hit) begin
      r_val[ix][vic] = 1; r_tag[ix][vic] = t; r_dirty[ix][vic] = we && wb;
    end else if (we && wb) begin
      r_dirty[ix][hw] = 1;
    end
    if (we) gold[addr] = wd;
  endtask

  task automatic random_run(int n, bit wb_only);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = nxt();
      access(r[0], wb_only ? 1'b1 : r[1],
             {2'b00, r[7:5], 1'b0, r[4:3], r[9:8]}, nxt(), r[11:10]);
    end
  endtask

  initial begin
    do_reset();
    // sweep: every set and offset, loads then stores then loads back
    for (int s = 0; s < SETS; s++)
      for (int o = 0; o < LW; o++)
        access(1'b0, 1'b1, {TAG_W'(1), IDX_W'(s), OFF_W'(o)}, '0, WAY_W'(s));
    for (int s = 0; s < SETS; s++)
      for (int o = 0; o < LW; o++)
        access(1'b1, s[0], {TAG_W'(2 + o), IDX_W'(s), OFF_W'(o)},
               32'hA000_0000 + 32'(s * 16 + o), WAY_W'(o));
    for (int s = 0; s < SETS; s++)
      for (int o = 0; o < LW; o++)
        access(1'b0, 1'b0, {TAG_W'(2 + o), IDX_W'(s), OFF_W'(o)}, '0, WAY_W'((o + 1) % 4));
    random_run(400, 1'b0);
    do_reset();
    random_run(300, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule